// File: doc/BRIEF.md
# Global Trigger Decision and Accept-Message Unit

This block sits at the centre of a multi-tower detector's trigger. Each cycle it gathers fast trigger primitives from every tower and from an anti-coincidence shield. Each tower supplies a calorimeter low-threshold flag, a calorimeter high-threshold flag and a tracker layer-coincidence flag. The shield supplies one low-threshold and one high-threshold flag per channel, and each shield channel can be masked on its own. The block forms five trigger conditions, qualifies them with per-condition enables and decides whether to accept the event.

On an accept, the block captures a timestamp, an event number, the ID of the destination processor and the set of conditions that fired. It then sends them as one serial message on a single output line. Destination processors are served in rotation. While a downstream busy / flow-control input is high, or while a message is still on the line, no new accept can happen. Every busy cycle is added to a dead-time counter. Software sets the masks, the enables and the processor count, and clears the event number, through a simple register write port.

Top module: `gtrig_top`

## Requirements
- R1: After reset the serial line is low, the dead-time count is 0, all shield mask bits are clear, all five condition enables are set, the processor count is 4, and the timestamp, event number and destination ID are 0.
- R2: Register address 0 holds the low-threshold shield mask and address 1 the high-threshold shield mask. Mask bit i = 1 removes shield channel i from the OR of that threshold. Unmasked channels are ORed.
- R3: Condition bits are: bit0 any calorimeter low, bit1 any calorimeter high, bit2 any tracker coincidence, bit3 shield low OR, bit4 shield high OR. Address 2 holds one enable bit per condition. An accept occurs when a satisfied condition is enabled. The message's type field equals the satisfied-and-enabled bits.
- R4: The 16-bit event number increments after each accept. A write to address 4 (any data) clears it to 0.
- R5: The 4-bit destination ID starts at 0 and advances by one on each accept only. It wraps to 0 after N-1, where N is the low 4 bits of address 3 (0 is treated as 1).
- R6: The line idles low. A message is 43 bits, one per cycle: start bit 1, then the destination (4 bits), timestamp (16), event number (16) and type (5), each MSB first, then a parity bit that makes the total count of ones in the 41 field bits plus parity odd.
- R7: No accept occurs while the busy input is high or while a message is still being sent, up to and including the cycle that shows its parity bit.
- R8: The 32-bit dead-time count increments once per clock with the busy input high and holds otherwise.
- R9: The timestamp counts clock edges since reset. The message carries the value held just before the accepting edge.
- R10: The start bit appears on the line in the cycle right after the one in which the trigger inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| towerCalLo | input | 16 | Calorimeter low flag per tower |
| towerCalHi | input | 16 | Calorimeter high flag per tower |
| towerTkr | input | 16 | Tracker coincidence flag per tower |
| shieldLo | input | 18 | Shield low flag per channel |
| shieldHi | input | 18 | Shield high flag per channel |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgWrData | input | 32 | Register write data |
| busyIn | input | 1 | Downstream busy / flow control |
| msgLine | output | 1 | Serial accept message |
| deadTime | output | 32 | Dead-time cycle count |

## Verification
Each accept's fields are decoded from the line, so a wrong event, destination or timestamp register shows up in the next message, within 43 cycles of the fault. A wrong mask or enable shows as a frame that appears when it should not, or fails to appear, one cycle after the stimulus. A corrupted type field or parity shows in that message's final bits. A dead-time counter that runs when it should not is visible directly on its output within one clock.

// File: rtl/gtrig_pkg.sv
package gtrig_pkg;
  localparam int COND_N = 5;
  localparam int DEST_W = 4;

  typedef struct packed {
    logic              load;
    logic              shift;
    logic              clrEvt;
    logic [COND_N-1:0] trigType;
    logic [DEST_W-1:0] numProc;
  } ctrlStrobe_t;
endpackage

// File: rtl/gtrig_mask_or.sv
module gtrig_mask_or #(
  parameter int WIDTH = 18
) (
  input  logic [WIDTH-1:0] chanIn,
  input  logic [WIDTH-1:0] chanMask,
  output logic             anyHit
);
  // masked channels drop out of the combined OR
  assign anyHit = |(chanIn & ~chanMask);
endmodule

// File: rtl/gtrig_ctrl.sv
module gtrig_ctrl import gtrig_pkg::*; #(
  parameter int NUM_TOWERS = 16,
  parameter int SHIELD_CH  = 18,
  parameter int FRAME_W    = 43,
  parameter int DEAD_W     = 32,
  parameter int DEF_PROCS  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_TOWERS-1:0] towerCalLo,
  input  logic [NUM_TOWERS-1:0] towerCalHi,
  input  logic [NUM_TOWERS-1:0] towerTkr,
  input  logic [SHIELD_CH-1:0]  shieldLo,
  input  logic [SHIELD_CH-1:0]  shieldHi,
  input  logic                  cfgWrEn,
  input  logic [2:0]            cfgAddr,
  input  logic [31:0]           cfgWrData,
  input  logic                  busyIn,
  output ctrlStrobe_t           strobe,
  output logic [DEAD_W-1:0]     deadTime
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [SHIELD_CH-1:0] maskLo, maskHi;
  logic [COND_N-1:0]    condEn;
  logic [DEST_W-1:0]    numProc;
  logic [CNT_W-1:0]     txCnt;
  logic [COND_N-1:0]    cond;
  logic                 shLoHit, shHiHit, accept;

  gtrig_mask_or #(.WIDTH(SHIELD_CH)) u_orLo (
    .chanIn(shieldLo), .chanMask(maskLo), .anyHit(shLoHit));
  gtrig_mask_or #(.WIDTH(SHIELD_CH)) u_orHi (
    .chanIn(shieldHi), .chanMask(maskHi), .anyHit(shHiHit));

  always_comb begin
    cond    = '0;
    cond[0] = |towerCalLo;
    cond[1] = |towerCalHi;
    cond[2] = |towerTkr;
    cond[3] = shLoHit;
    cond[4] = shHiHit;
  end

  assign accept = (|(cond & condEn)) && !busyIn && (txCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskLo  <= '0;
      maskHi  <= '0;
      condEn  <= '1;
      numProc <= DEST_W'(DEF_PROCS);
    end else if (cfgWrEn) begin
      case (cfgAddr)
        3'd0: maskLo  <= cfgWrData[SHIELD_CH-1:0];
        3'd1: maskHi  <= cfgWrData[SHIELD_CH-1:0];
        3'd2: condEn  <= cfgWrData[COND_N-1:0];
        3'd3: numProc <= cfgWrData[DEST_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              txCnt <= '0;
    else if (accept)        txCnt <= CNT_W'(FRAME_W);
    else if (txCnt != '0)   txCnt <= txCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       deadTime <= '0;
    else if (busyIn) deadTime <= deadTime + 1'b1;
  end

  always_comb begin
    strobe.load     = accept;
    strobe.shift    = (txCnt != '0);
    strobe.clrEvt   = cfgWrEn && (cfgAddr == 3'd4);
    strobe.trigType = cond & condEn;
    strobe.numProc  = numProc;
  end

  // R8: dead time only moves while busy
  p_dead_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busyIn |=> $stable(deadTime));
endmodule

// File: rtl/gtrig_dp.sv
module gtrig_dp import gtrig_pkg::*; #(
  parameter int TS_W    = 16,
  parameter int EVT_W   = 16,
  parameter int FRAME_W = 43
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        msgLine
);
  localparam int FIELD_W = DEST_W + TS_W + EVT_W + COND_N;

  logic [TS_W-1:0]    tsCnt;
  logic [EVT_W-1:0]   evtNum;
  logic [DEST_W-1:0]  destId;
  logic [FRAME_W-1:0] sreg;
  logic [FIELD_W-1:0] fields;
  logic [DEST_W:0]    destNext, procLimit;

  assign fields    = {destId, tsCnt, evtNum, strobe.trigType};
  assign destNext  = {1'b0, destId} + 1'b1;
  assign procLimit = (strobe.numProc == '0) ? (DEST_W+1)'(1) : {1'b0, strobe.numProc};

  always_ff @(posedge clk) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              evtNum <= '0;
    else if (strobe.clrEvt) evtNum <= '0;
    else if (strobe.load)   evtNum <= evtNum + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) destId <= '0;
    else if (strobe.load)
      destId <= (destNext >= procLimit) ? '0 : destNext[DEST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             sreg <= '0;
    else if (strobe.load)  sreg <= {1'b1, fields, ~(^fields)};
    else if (strobe.shift) sreg <= {sreg[FRAME_W-2:0], 1'b0};
  end

  assign msgLine = sreg[FRAME_W-1];

  // R6/R10: a load shows the start bit next cycle
  p_start_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> msgLine);
  // R7: no second accept right behind the first
  p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !strobe.load);
  // R4: event number steps by one per accept
  p_evt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.clrEvt) |=> evtNum == EVT_W'($past(evtNum) + 1'b1));
endmodule

// File: rtl/gtrig_top.sv
module gtrig_top import gtrig_pkg::*; #(
  parameter int NUM_TOWERS = 16,
  parameter int SHIELD_CH  = 18,
  parameter int TS_W       = 16,
  parameter int EVT_W      = 16,
  parameter int DEAD_W     = 32,
  parameter int DEF_PROCS  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_TOWERS-1:0] towerCalLo,
  input  logic [NUM_TOWERS-1:0] towerCalHi,
  input  logic [NUM_TOWERS-1:0] towerTkr,
  input  logic [SHIELD_CH-1:0]  shieldLo,
  input  logic [SHIELD_CH-1:0]  shieldHi,
  input  logic                  cfgWrEn,
  input  logic [2:0]            cfgAddr,
  input  logic [31:0]           cfgWrData,
  input  logic                  busyIn,
  output logic                  msgLine,
  output logic [DEAD_W-1:0]     deadTime
);
  localparam int FRAME_W = 2 + DEST_W + TS_W + EVT_W + COND_N;

  ctrlStrobe_t strobe;

  gtrig_ctrl #(
    .NUM_TOWERS(NUM_TOWERS), .SHIELD_CH(SHIELD_CH), .FRAME_W(FRAME_W),
    .DEAD_W(DEAD_W), .DEF_PROCS(DEF_PROCS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .towerCalLo(towerCalLo), .towerCalHi(towerCalHi), .towerTkr(towerTkr),
    .shieldLo(shieldLo), .shieldHi(shieldHi),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .busyIn(busyIn), .strobe(strobe), .deadTime(deadTime));

  gtrig_dp #(.TS_W(TS_W), .EVT_W(EVT_W), .FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .msgLine(msgLine));
endmodule

// File: tb/sim_gtrig_top.sv
`timescale 1ns/1ps
module sim_gtrig_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] towerCalLo = '0, towerCalHi = '0, towerTkr = '0;
  logic [17:0] shieldLo = '0, shieldHi = '0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        busyIn = 1'b0;
  logic        msgLine;
  logic [31:0] deadTime;

  int checks = 0, failures = 0;
  logic [15:0] cyc;
  logic [15:0] expEvt = '0;
  logic [3:0]  expDest = '0;
  int          numProc = 4;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= '0;
    else       cyc <= cyc + 1'b1;
  end

  gtrig_top u0 (.*);

  // fields: calLo, calHi, tkr, shieldLo, shieldHi, expected type
  localparam int NV = 7;
  localparam logic [88:0] VEC [NV] = '{
    {16'h0008, 16'h0000, 16'h0000, 18'h00000, 18'h00000, 5'b00001},
    {16'h0000, 16'h8000, 16'h0000, 18'h00000, 18'h00000, 5'b00010},
    {16'h0000, 16'h0000, 16'h0001, 18'h00000, 18'h00000, 5'b00100},
    {16'h0000, 16'h0000, 16'h0000, 18'h20000, 18'h00000, 5'b01000},
    {16'h0000, 16'h0000, 16'h0000, 18'h00000, 18'h00001, 5'b10000},
    {16'h0100, 16'h0000, 16'h0400, 18'h00000, 18'h00040, 5'b10101},
    {16'hFFFF, 16'h0001, 16'h0002, 18'h3FFFF, 18'h10000, 5'b11111}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input [15:0] cl, ch, tk, input [17:0] sl, sh);
    towerCalLo = cl; towerCalHi = ch; towerTkr = tk; shieldLo = sl; shieldHi = sh;
  endtask

  task automatic cfgWrite(input [2:0] a, input [31:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  // present a trigger, then decode the message from the line
  task automatic sendFrame(input [15:0] cl, ch, tk, input [17:0] sl, sh,
                           input [4:0] expType, input bit holdAll, input string tag);
    logic [42:0] frame;
    logic [15:0] expTs;
    @(negedge clk); drive(cl, ch, tk, sl, sh); expTs = cyc;
    frame = '0;
    for (int i = 0; i < 43; i++) begin
      @(negedge clk);
      if ((!holdAll && i == 0) || (holdAll && i == 42)) drive('0, '0, '0, '0, '0);
      frame = {frame[41:0], msgLine};
    end
    check({tag, " R10 start bit"}, frame[42], 1'b1);
    check({tag, " R5 dest"}, frame[41:38], expDest);
    check({tag, " R9 timestamp"}, frame[37:22], expTs);
    check({tag, " R4 event"}, frame[21:6], expEvt);
    check({tag, " R3 type"}, frame[5:1], expType);
    check({tag, " R6 odd parity"}, ^frame[41:0], 1'b1);
    expEvt  = expEvt + 1'b1;
    expDest = (int'(expDest) + 1 >= numProc) ? 4'd0 : expDest + 1'b1;
  endtask

  task automatic noAccept(input [15:0] cl, ch, tk, input [17:0] sl, sh, input string tag);
    logic seen;
    seen = 1'b0;
    @(negedge clk); drive(cl, ch, tk, sl, sh);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); seen = seen | msgLine;
    end
    drive('0, '0, '0, '0, '0);
    check(tag, seen, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 line idle after reset", msgLine, 1'b0);
    check("R1 dead time zero", deadTime, 32'd0);

    // default masks/enables/proc count (R1) exercised by the table walk
    for (int v = 0; v < NV; v++)
      sendFrame(VEC[v][88:73], VEC[v][72:57], VEC[v][56:41], VEC[v][40:23],
                VEC[v][22:5], VEC[v][4:0], (v == NV - 1), $sformatf("vec%0d", v));

    // R2 masking of shield channel 5 on the low threshold
    cfgWrite(3'd0, 32'h20);
    noAccept('0, '0, '0, 18'h00020, '0, "R2 masked channel ignored");
    sendFrame('0, '0, '0, 18'h00060, '0, 5'b01000, 1'b0, "R2 unmasked neighbour");

    // R3 disable calorimeter low
    cfgWrite(3'd2, 32'h1E);
    noAccept(16'h0010, '0, '0, '0, '0, "R3 disabled condition ignored");
    sendFrame(16'h0010, '0, 16'h0020, '0, '0, 5'b00100, 1'b0, "R3 enabled subset");

    // R5 two processors
    cfgWrite(3'd3, 32'd2); numProc = 2;
    sendFrame('0, 16'h0001, '0, '0, '0, 5'b00010, 1'b0, "R5 n2 a");
    sendFrame('0, 16'h0001, '0, '0, '0, 5'b00010, 1'b0, "R5 n2 b");
    sendFrame('0, 16'h0001, '0, '0, '0, 5'b00010, 1'b0, "R5 n2 c");

    // R4 clear event number
    cfgWrite(3'd4, 32'd0); expEvt = '0;
    sendFrame('0, '0, '0, '0, 18'h00002, 5'b10000, 1'b0, "R4 after clear");

    // R7/R8 busy holds off accepts and counts dead time
    @(negedge clk); d0 = deadTime;
    busyIn = 1'b1; drive('0, 16'h0004, '0, '0, '0);
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk); seen = seen | msgLine;
      end
      check("R8 dead time counted", deadTime, d0 + 32'd5);
      busyIn = 1'b0; drive('0, '0, '0, '0, '0);
      check("R7 no accept while busy", seen, 1'b0);
    end
    repeat (3) @(negedge clk);
    check("R8 dead time holds", deadTime, d0 + 32'd5);
    check("R7 line still idle", msgLine, 1'b0);
    sendFrame('0, 16'h0004, '0, '0, '0, 5'b00010, 1'b0, "R7 after busy");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule